// File: doc/BRIEF.md
# Enable-Aware Multichannel Sample Packer

This block gathers four 16-bit channel streams (the I and Q components of two receive paths) into a single 64-bit output word. All four channels share one sample strobe, `in_valid`. That strobe may fire only once every few clocks, and samples are taken only on strobed cycles. A static enable mask, set by software, selects which channels take part. The 64-bit word is divided equally among the enabled channels. With one channel enabled, that channel fills all four slots. With two enabled, each gets two slots. With all four enabled, each gets one slot.

Within a strobed cycle, the enabled channels are compacted in ascending index order into consecutive 16-bit slots. Successive strobed cycles fill higher slots, so the lowest slot holds the oldest sample and the highest slot holds the newest. When all four slots are filled, the word is presented with `out_valid` and held until `out_ready` accepts it. If another word completes while the previous one is still waiting, the waiting word is replaced and a sticky overflow flag is raised. Changing the enable mask discards any partly built word. Masks with zero or three channels enabled produce nothing.

Top module: `sample_packer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_valid` and `overflow` are 0.
- R2: A sample is taken only in a cycle with `in_valid` high. The contents of `in_data` in other cycles have no effect on any output word.
- R3: Channel c arrives on `in_data[16c+15:16c]`. Within one accepted cycle, the enabled channels occupy consecutive 16-bit slots in ascending channel order.
- R4: Slot k of `out_data` is bits `[16k+15:16k]`. A sample accepted earlier always sits in a lower slot than a sample accepted later within the same word.
- R5: With N = 1, 2 or 4 channels enabled, one word is produced for every 4/N accepted cycles. `out_valid` rises in the cycle after the accepted cycle that fills the last slot.
- R6: With 0 or 3 channels enabled, no samples are taken and `out_valid` never rises from new data.
- R7: In a cycle where `ch_enable` differs from its value in the previous cycle, that cycle's sample is dropped and the partial word is discarded. The next word starts at slot 0. After reset, the previous value counts as all zeros.
- R8: While `out_valid` is high and `out_ready` is low, and no new word completes, `out_valid` stays high and `out_data` stays unchanged. A word is accepted on a clock edge where both are high.
- R9: If a word completes while `out_valid` is high and `out_ready` is low, the new word replaces the waiting one and `overflow` goes to 1. `overflow` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Shared sample strobe for all channels |
| in_data | input | 64 | Four channel samples, channel c in bits 16c+15:16c |
| ch_enable | input | 4 | Static channel enable mask, bit c for channel c |
| out_ready | input | 1 | Downstream can accept the presented word |
| out_valid | output | 1 | A packed word is presented |
| out_data | output | 64 | Packed word, slot k in bits 16k+15:16k, oldest in slot 0 |
| overflow | output | 1 | Sticky flag: a completed word was lost |

## Verification
The bench sweeps all sixteen enable masks. For each mask it applies four strobed cycles with three idle clocks between them, and drives a junk pattern on the data bus during the idle clocks. Every sample carries its cycle number and channel index, so a single comparison can tell a wrong slot order, a wrong channel compaction, a word taken from idle cycles, or a wrong word count for one, two or four channels. The three-channel and zero-channel masks must produce no words at all. Separate sequences change the mask in the middle of a word to check that the partial word is flushed, and hold `out_ready` low across two completed words to check that the waiting word is held, then replaced, and that the overflow flag stays set.

// File: rtl/spk_pkg.sv
package spk_pkg;

    // True when n channels divide a word of total slots evenly (power of two, nonzero).
    function automatic logic splits_evenly(input int unsigned n, input int unsigned total);
        return (n != 0) && (n <= total) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/spk_compact.sv
module spk_compact #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = $clog2(NUM_CH + 1)
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] lanes,
    input  logic [NUM_CH-1:0]          mask,
    output logic [NUM_CH*SAMPLE_W-1:0] packed_lanes,
    output logic [CNT_W-1:0]           active_cnt
);

    always_comb begin
        int pos;
        pos          = 0;
        packed_lanes = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (mask[c]) begin
                packed_lanes[pos*SAMPLE_W +: SAMPLE_W] = lanes[c*SAMPLE_W +: SAMPLE_W];
                pos = pos + 1;
            end
        end
        active_cnt = CNT_W'(pos);
    end

endmodule

// File: rtl/spk_fill.sv
module spk_fill
    import spk_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = $clog2(NUM_CH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic [NUM_CH-1:0]          mask,
    input  logic [NUM_CH*SAMPLE_W-1:0] packed_lanes,
    input  logic [CNT_W-1:0]           active_cnt,
    output logic                       word_done,
    output logic [NUM_CH*SAMPLE_W-1:0] word_next
);

    localparam int WORD_W = NUM_CH * SAMPLE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  ptr;
        logic [WORD_W-1:0] acc;
        logic [NUM_CH-1:0] mask;
    } fill_t;

    fill_t st_d, st_q;
    logic  mask_moved;
    logic  usable;

    always_comb begin
        int base;
        int span;
        st_d       = st_q;
        word_done  = 1'b0;
        word_next  = st_q.acc;
        mask_moved = (mask != st_q.mask);
        usable     = splits_evenly(int'(active_cnt), NUM_CH);
        base       = int'(st_q.ptr);
        span       = int'(active_cnt);
        st_d.mask  = mask;
        if (mask_moved) begin
            st_d.ptr = '0;
            st_d.acc = '0;
        end else if (take && usable) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (k < span && (base + k) < NUM_CH) begin
                    word_next[(base + k)*SAMPLE_W +: SAMPLE_W] = packed_lanes[k*SAMPLE_W +: SAMPLE_W];
                end
            end
            if (base + span >= NUM_CH) begin
                word_done = 1'b1;
                st_d.ptr  = '0;
                st_d.acc  = '0;
            end else begin
                st_d.ptr = CNT_W'(base + span);
                st_d.acc = word_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a mask change leaves the fill pointer at slot 0
    a_r7_flush_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (mask != st_q.mask) |=> (st_q.ptr == '0));

    // R2: without a strobe and with a steady mask the partial word does not move
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && mask == st_q.mask) |=> ($stable(st_q.ptr) && $stable(st_q.acc)));

    // R6: unusable channel counts never advance the pointer
    a_r6_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!splits_evenly(int'(active_cnt), NUM_CH)) |=> (st_q.ptr == '0));

    // R5: the pointer never reaches a full word while stored
    a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.ptr) < NUM_CH);

endmodule

// File: rtl/spk_out.sv
module spk_out #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_next,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              overflow
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
        logic              ovf;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready) begin
            st_d.vld = 1'b0;
        end
        if (word_done) begin
            st_d.vld  = 1'b1;
            st_d.data = word_next;
            if (st_q.vld && !out_ready) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign overflow  = st_q.ovf;

    // R8: an unaccepted word is held unchanged
    a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && !out_ready && !word_done) |=> (st_q.vld && $stable(st_q.data)));

    // R9: a completed word arriving on a stalled one raises overflow
    a_r9_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && st_q.vld && !out_ready) |=> st_q.ovf);

    // R9: overflow is sticky
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

endmodule

// File: rtl/sample_packer.sv
module sample_packer #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] in_data,
    input  logic [NUM_CH-1:0]          ch_enable,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [NUM_CH*SAMPLE_W-1:0] out_data,
    output logic                       overflow
);

    localparam int WORD_W = NUM_CH * SAMPLE_W;
    localparam int CNT_W  = $clog2(NUM_CH + 1);

    logic [WORD_W-1:0] packed_lanes;
    logic [CNT_W-1:0]  active_cnt;
    logic              word_done;
    logic [WORD_W-1:0] word_next;

    spk_compact #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_compact (
        .lanes        (in_data),
        .mask         (ch_enable),
        .packed_lanes (packed_lanes),
        .active_cnt   (active_cnt)
    );

    spk_fill #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (in_valid),
        .mask         (ch_enable),
        .packed_lanes (packed_lanes),
        .active_cnt   (active_cnt),
        .word_done    (word_done),
        .word_next    (word_next)
    );

    spk_out #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word_next (word_next),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .overflow  (overflow)
    );

    // R1: outputs are quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !overflow));

endmodule

// File: tb/sample_packer_tb.sv
module sample_packer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [3:0]  ch_enable = '0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [63:0] out_data;
    logic        overflow;

    int tests = 0;
    int fails = 0;
    int gcount = 0;
    int exp_wr = 0;
    int exp_rd = 0;
    logic [63:0] expq [0:63];
    logic [15:0] seq  [0:15];
    bit done_flag = 0;

    localparam logic [63:0] JUNK = 64'hDEAD_BEEF_0BAD_F00D;

    always #5 clk = ~clk;

    sample_packer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .ch_enable(ch_enable), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .overflow(overflow)
    );

    function automatic logic [15:0] smp(input int g, input int c);
        return 16'(((g & 16'h0FFF) << 4) | c);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // drive one cycle at the falling edge
    task automatic drive(input bit v);
        @(negedge clk);
        in_valid = v;
        if (v) begin
            for (int c = 0; c < 4; c++) in_data[c*16 +: 16] = smp(gcount, c);
            gcount++;
        end else begin
            in_data = JUNK;
        end
    endtask

    task automatic push_exp(input logic [63:0] w);
        expq[exp_wr % 64] = w;
        exp_wr++;
    endtask

    // R3 R4 R5 monitor: every accepted word matches the bench model
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && !done_flag) begin
            if (exp_rd < exp_wr) begin
                check(out_data == expq[exp_rd % 64], "R3/R4 word content", out_data, expq[exp_rd % 64]);
                exp_rd++;
            end else begin
                check(1'b0, "R6 unexpected word", out_data, 64'h0);
            end
        end
    end

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'h0);
        check(overflow == 1'b0, "R1 overflow in reset", 64'(overflow), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && overflow == 1'b0, "R1 after release", {62'h0, out_valid, overflow}, 64'h0);

        // Sweep all masks (R2 R3 R4 R5 R6)
        for (int m = 0; m < 16; m++) begin
            int n;
            int base_g;
            int ns;
            @(negedge clk);
            in_valid = 1'b0;
            ch_enable = 4'(m);
            drive(0);
            drive(0);
            n = $countones(4'(m));
            base_g = gcount;
            ns = 0;
            for (int v = 0; v < 4; v++)
                for (int c = 0; c < 4; c++)
                    if (m[c]) begin seq[ns] = smp(base_g + v, c); ns++; end
            if (n == 1 || n == 2 || n == 4) begin
                for (int w = 0; w < n; w++)
                    push_exp({seq[4*w+3], seq[4*w+2], seq[4*w+1], seq[4*w]});
            end
            for (int v = 0; v < 4; v++) begin
                drive(1);
                drive(0);
                drive(0);
                drive(0);
            end
            drive(0);
            drive(0);
            @(negedge clk);
            check(exp_rd == exp_wr, (n == 1 || n == 2 || n == 4) ? "R5 word count" : "R6 no words",
                  64'(exp_rd), 64'(exp_wr));
            check(overflow == 1'b0, "R9 no overflow with ready", 64'(overflow), 64'h0);
        end

        // R7 flush on mask change
        begin
            logic [15:0] a0, a1, b0, b1;
            @(negedge clk);
            ch_enable = 4'b0001;
            drive(0); drive(0);
            drive(1); drive(1);
            @(negedge clk);
            ch_enable = 4'b0011;
            in_valid = 1'b1;
            in_data = JUNK;
            gcount++;
            a0 = smp(gcount, 0); a1 = smp(gcount, 1);
            b0 = smp(gcount + 1, 0); b1 = smp(gcount + 1, 1);
            push_exp({b1, b0, a1, a0});
            drive(1); drive(1);
            drive(0); drive(0);
            @(negedge clk);
            check(exp_rd == exp_wr, "R7 flushed word count", 64'(exp_rd), 64'(exp_wr));
        end

        // R8 R9 stall and overflow
        begin
            logic [63:0] wa, wb;
            @(negedge clk);
            out_ready = 1'b0;
            ch_enable = 4'b1111;
            drive(0); drive(0);
            drive(1);
            wa = in_data;
            drive(0);
            check(out_valid == 1'b1, "R5 valid one cycle after fill", 64'(out_valid), 64'h1);
            check(out_data == wa, "R4 full-mask word", out_data, wa);
            check(overflow == 1'b0, "R9 no overflow yet", 64'(overflow), 64'h0);
            drive(0); drive(0);
            check(out_valid == 1'b1 && out_data == wa, "R8 held while stalled", out_data, wa);
            drive(1);
            wb = in_data;
            drive(0);
            check(overflow == 1'b1, "R9 overflow set", 64'(overflow), 64'h1);
            check(out_data == wb, "R9 word replaced", out_data, wb);
            push_exp(wb);
            @(negedge clk);
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            check(out_valid == 1'b0, "R8 accepted clears valid", 64'(out_valid), 64'h0);
            check(overflow == 1'b1, "R9 overflow sticky", 64'(overflow), 64'h1);
            check(exp_rd == exp_wr, "R8 one acceptance", 64'(exp_rd), 64'(exp_wr));
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            check(overflow == 1'b0, "R1 reset clears overflow", 64'(overflow), 64'h0);
        end

        finish_run();
    end

endmodule